// File: doc/BRIEF.md
# Page Access Guard with Fault Log

This block sits after the page-table walker of a memory management unit. Once the walker has found the entry for a page, or has failed with its own error code, the block judges the access against the entry's 3-bit permission field and decides which rights may be cached for the page. An access is described by three flags: write, instruction fetch and supervisor. The decision comes back one cycle after a check request. It consists of an error code, a read grant, a write grant and, where trapping is allowed, an instruction-fault or data-fault pulse.

Every fault is recorded in a status register and a fault address register. Software reads both through a small read port. A read of the status register clears it. If a second fault arrives before software has read the first, the status register shows an overflow. A no-fault control bit and a traps-disabled input keep faults from trapping. In that case the page is opened for read and write.

Top module: `acc_guard`

## Requirements
- R1: The access index is {acc_write, acc_fetch, acc_super}, with the supervisor flag in bit 0. It appears in bits 7:5 of the status register after a fault.
- R2: With no walker error and `nofault_en` low, `err_code` follows the fixed 8x8 permission table indexed by access index and `pte_perm`. The value 0 means allowed, 2 means protection error and 3 means privilege violation.
- R3: If a fault arrives while the status register is nonzero and is not being read in that cycle, the register is first reset to 1 (overflow) and the new fault bits are then merged in.
- R4: On a fault, the access index shifted left by 5, the error code and the valid bit 2 are ORed into the status register.
- R5: On a fault, the fault address register takes the full `vaddr`.
- R6: With `nofault_en` high, a permission error is not reported. `err_code` is 0, no trap pulse is raised and the status register is unchanged.
- R7: On an allowed access, `grant_rd` is 1. `grant_wr` is 1 only when `pte_mod` is 1 and the write table allows it. A supervisor may write when the permission is odd. A user may write only for permission 1 or 3.
- R8: On a fault while `nofault_en` or `traps_off` is high, both grants are 1 and no trap pulse is raised. The fault is still logged and `err_code` still carries it.
- R9: On a trapping fault, both grants are 0. `trap_ifetch` pulses for fetches and `trap_data` pulses for all other accesses, never both.
- R10: `reg_rd` with `reg_sel`=0 returns the status register and clears it. `reg_sel`=1 returns the fault address. A fault in the same cycle as a status read is merged into a cleared register, and the read returns the old value.
- R11: A nonzero `walk_err` takes priority over the permission check. It is passed to `err_code` unchanged and always counts as a fault, whatever `nofault_en` is.
- R12: `chk_done` and `reg_rvalid` pulse exactly one cycle after `chk_req` and `reg_rd`. After reset, all outputs and both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_req | input | 1 | Start a permission check this cycle |
| acc_write | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is made in supervisor mode |
| pte_perm | input | 3 | Permission field of the page entry |
| pte_mod | input | 1 | Modified bit of the page entry |
| walk_err | input | ERR_W | Error code from the table walker, 0 if the walk succeeded |
| nofault_en | input | 1 | No-fault control bit |
| traps_off | input | 1 | Traps are disabled in the CPU |
| vaddr | input | VA_W | Virtual address of the access |
| chk_done | output | 1 | Check result valid |
| err_code | output | ERR_W | Final error code |
| grant_rd | output | 1 | Read may be mapped |
| grant_wr | output | 1 | Write may be mapped |
| trap_ifetch | output | 1 | Instruction access fault pulse |
| trap_data | output | 1 | Data access fault pulse |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the status register, 1 the fault address |
| reg_rdata | output | VA_W | Read data |
| reg_rvalid | output | 1 | Read data valid |

## Verification
The bench sweeps all 64 combinations of access index and permission. A transposed or shifted table shows up as a wrong `err_code` or grant in some cell. It leaves faults standing without reading them, to provoke overflow. A design that forgets the reset-to-1 step would keep stale error bits, and a design that checks only the new fault would never raise bit 0. Three further cases each expose a specific error: a status read in the same cycle as a fault catches a design that loses the new fault or flags a false overflow. A clean writable page reached a write grant only by ignoring the modified bit. Mixing walker errors with no-fault mode catches a design that lets the no-fault bit hide walker errors.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

  typedef enum logic [1:0] {
    PE_OK   = 2'd0,
    PE_PROT = 2'd2,
    PE_PRIV = 2'd3
  } perm_err_e;

  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_ADDR   = 1'b1;

  // Protection-error columns per access index, bit n = permission n.
  function automatic logic [7:0] prot_cols(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1: prot_cols = 8'h10;
      3'd2, 3'd3: prot_cols = 8'h23;
      3'd4:       prot_cols = 8'h35;
      3'd5:       prot_cols = 8'h55;
      3'd6:       prot_cols = 8'h37;
      default:    prot_cols = 8'h77;
    endcase
  endfunction

  // User accesses (idx[0]==0) to supervisor-only pages (perm 6,7) are privilege errors.
  function automatic perm_err_e perm_code(input logic [2:0] idx, input logic [2:0] perm);
    logic [7:0] cols;
    cols = prot_cols(idx);
    if (!idx[0] && (perm[2:1] == 2'b11)) perm_code = PE_PRIV;
    else if (cols[perm])                 perm_code = PE_PROT;
    else                                 perm_code = PE_OK;
  endfunction

  // Write table: odd permissions are writable; users lose the upper four.
  function automatic logic write_ok(input logic is_user, input logic [2:0] perm);
    write_ok = perm[0] && (!is_user || !perm[2]);
  endfunction

endpackage

// File: rtl/acc_perm_eval.sv
module acc_perm_eval
  import acc_guard_pkg::*;
#(
  parameter int ERR_W = 10
) (
  input  logic             acc_write,
  input  logic             acc_fetch,
  input  logic             acc_super,
  input  logic [2:0]       pte_perm,
  input  logic [ERR_W-1:0] walk_err,
  input  logic             nofault_en,
  output logic [2:0]       acc_idx,
  output logic             eval_fault,
  output logic [ERR_W-1:0] eval_err,
  output logic             wr_allowed
);

  perm_err_e  pcode;
  logic [1:0] pcode_bits;
  logic       walk_hit;
  logic       perm_hit;

  assign acc_idx    = {acc_write, acc_fetch, acc_super};
  assign pcode      = perm_code(acc_idx, pte_perm);
  assign pcode_bits = pcode;
  assign walk_hit   = |walk_err;
  assign perm_hit   = (pcode != PE_OK) && !nofault_en;
  assign eval_fault = walk_hit || perm_hit;
  assign eval_err   = walk_hit ? walk_err
                    : (perm_hit ? ERR_W'(pcode_bits) : '0);
  assign wr_allowed = write_ok(!acc_super, pte_perm);

endmodule

// File: rtl/acc_fault_log.sv
module acc_fault_log
  import acc_guard_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int ERR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_evt,
  input  logic [2:0]       acc_idx,
  input  logic [ERR_W-1:0] fault_err,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             reg_rd,
  input  logic             reg_sel,
  output logic [VA_W-1:0]  reg_rdata,
  output logic             reg_rvalid
);

  localparam int IDX_LSB = 5;

  logic [ERR_W-1:0] fsr;
  logic [VA_W-1:0]  far;
  logic             clear_now;
  logic [ERR_W-1:0] fsr_base;
  logic [ERR_W-1:0] ovf_seed;
  logic [ERR_W-1:0] fsr_merge;

  assign clear_now = reg_rd && (reg_sel == SEL_STATUS);
  assign fsr_base  = clear_now ? '0 : fsr;
  assign ovf_seed  = (|fsr_base) ? ERR_W'(1) : '0;
  assign fsr_merge = ovf_seed | (ERR_W'(acc_idx) << IDX_LSB) | fault_err | ERR_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr        <= '0;
      far        <= '0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      if (fault_evt) begin
        fsr <= fsr_merge;
        far <= vaddr;
      end else if (clear_now) begin
        fsr <= '0;
      end
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= (reg_sel == SEL_ADDR) ? far : VA_W'(fsr);
    end
  end

  p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt && (|fsr) && !clear_now |=> fsr[0]);

  p_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> fsr[1] && (fsr[IDX_LSB+2:IDX_LSB] == $past(acc_idx)));

  p_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> far == $past(vaddr));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_now && !fault_evt |=> fsr == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_evt && !clear_now |=> $stable(fsr) && $stable(far));

endmodule

// File: rtl/acc_guard.sv
module acc_guard
  import acc_guard_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int ERR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_req,
  input  logic             acc_write,
  input  logic             acc_fetch,
  input  logic             acc_super,
  input  logic [2:0]       pte_perm,
  input  logic             pte_mod,
  input  logic [ERR_W-1:0] walk_err,
  input  logic             nofault_en,
  input  logic             traps_off,
  input  logic [VA_W-1:0]  vaddr,
  output logic             chk_done,
  output logic [ERR_W-1:0] err_code,
  output logic             grant_rd,
  output logic             grant_wr,
  output logic             trap_ifetch,
  output logic             trap_data,
  input  logic             reg_rd,
  input  logic             reg_sel,
  output logic [VA_W-1:0]  reg_rdata,
  output logic             reg_rvalid
);

  logic [2:0]       acc_idx;
  logic             eval_fault;
  logic [ERR_W-1:0] eval_err;
  logic             wr_allowed;
  logic             fault_now;
  logic             suppress;
  logic             trap_now;

  acc_perm_eval #(.ERR_W(ERR_W)) u_eval (
    .acc_write  (acc_write),
    .acc_fetch  (acc_fetch),
    .acc_super  (acc_super),
    .pte_perm   (pte_perm),
    .walk_err   (walk_err),
    .nofault_en (nofault_en),
    .acc_idx    (acc_idx),
    .eval_fault (eval_fault),
    .eval_err   (eval_err),
    .wr_allowed (wr_allowed)
  );

  assign fault_now = chk_req && eval_fault;
  assign suppress  = nofault_en || traps_off;
  assign trap_now  = fault_now && !suppress;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_done    <= 1'b0;
      err_code    <= '0;
      grant_rd    <= 1'b0;
      grant_wr    <= 1'b0;
      trap_ifetch <= 1'b0;
      trap_data   <= 1'b0;
    end else begin
      chk_done    <= chk_req;
      trap_ifetch <= trap_now && acc_fetch;
      trap_data   <= trap_now && !acc_fetch;
      if (chk_req) begin
        err_code <= eval_err;
        if (eval_fault) begin
          grant_rd <= suppress;
          grant_wr <= suppress;
        end else begin
          grant_rd <= 1'b1;
          grant_wr <= pte_mod && wr_allowed;
        end
      end
    end
  end

  acc_fault_log #(.VA_W(VA_W), .ERR_W(ERR_W)) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_evt  (fault_now),
    .acc_idx    (acc_idx),
    .fault_err  (eval_err),
    .vaddr      (vaddr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );

  p_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> chk_done);

  p_one_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ifetch, trap_data}));

  p_trap_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> (trap_ifetch == $past(acc_fetch)) && !grant_rd && !grant_wr);

  p_wr_needs_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && !eval_fault && !pte_mod |=> !grant_wr && grant_rd);

  p_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now && suppress |=> grant_rd && grant_wr && !trap_ifetch && !trap_data);

  p_walk_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && (|walk_err) |=> err_code == $past(walk_err));

  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

endmodule

// File: tb/acc_guard_tb.sv
module acc_guard_tb;

  localparam int VA_W  = 32;
  localparam int ERR_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             chk_req = 1'b0;
  logic             acc_write = 1'b0, acc_fetch = 1'b0, acc_super = 1'b0;
  logic [2:0]       pte_perm = '0;
  logic             pte_mod = 1'b0;
  logic [ERR_W-1:0] walk_err = '0;
  logic             nofault_en = 1'b0, traps_off = 1'b0;
  logic [VA_W-1:0]  vaddr = '0;
  logic             chk_done;
  logic [ERR_W-1:0] err_code;
  logic             grant_rd, grant_wr, trap_ifetch, trap_data;
  logic             reg_rd = 1'b0, reg_sel = 1'b0;
  logic [VA_W-1:0]  reg_rdata;
  logic             reg_rvalid;

  always #4 clk = ~clk;

  acc_guard #(.VA_W(VA_W), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .acc_super(acc_super), .pte_perm(pte_perm),
    .pte_mod(pte_mod), .walk_err(walk_err), .nofault_en(nofault_en),
    .traps_off(traps_off), .vaddr(vaddr), .chk_done(chk_done),
    .err_code(err_code), .grant_rd(grant_rd), .grant_wr(grant_wr),
    .trap_ifetch(trap_ifetch), .trap_data(trap_data), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  int unsigned m_status = 0;
  int unsigned m_addr = 0;
  int tbl [8][8] = '{
    '{0,0,0,0,2,0,3,3}, '{0,0,0,0,2,0,0,0},
    '{2,2,0,0,0,2,3,3}, '{2,2,0,0,0,2,0,0},
    '{2,0,2,0,2,2,3,3}, '{2,0,2,0,2,0,2,0},
    '{2,2,2,0,2,2,3,3}, '{2,2,2,0,2,2,2,0}};

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_chk(input bit w, input bit f, input bit s, input int perm,
                         input bit mod, input int walk, input bit nf, input bit toff,
                         input int unsigned va, input bit rd_status, input string tag);
    int  idx, pe, e_err, e_rd, e_wr, e_ti, e_td;
    bit  fault, wr_tbl;
    int unsigned base, old_status;
    @(negedge clk);
    acc_write = w; acc_fetch = f; acc_super = s; pte_perm = perm[2:0];
    pte_mod = mod; walk_err = walk[ERR_W-1:0]; nofault_en = nf; traps_off = toff;
    vaddr = va; chk_req = 1'b1; reg_rd = rd_status; reg_sel = 1'b0;
    idx = (w ? 4 : 0) + (f ? 2 : 0) + (s ? 1 : 0);
    pe = tbl[idx][perm];
    wr_tbl = (perm % 2 == 1) && (s || perm < 4);
    fault = (walk != 0) || (pe != 0 && !nf);
    e_err = (walk != 0) ? walk : (nf ? 0 : pe);
    e_ti = 0; e_td = 0;
    if (!fault) begin
      e_rd = 1; e_wr = (mod && wr_tbl) ? 1 : 0;
    end else if (nf || toff) begin
      e_rd = 1; e_wr = 1;
    end else begin
      e_rd = 0; e_wr = 0;
      if (f) e_ti = 1; else e_td = 1;
    end
    old_status = m_status;
    base = rd_status ? 0 : m_status;
    if (fault) begin
      m_status = ((base != 0) ? 1 : 0) | (idx * 32) | e_err | 2;
      m_addr = va;
    end else begin
      m_status = base;
    end
    @(negedge clk);
    chk_req = 1'b0; reg_rd = 1'b0;
    chk({tag, " R12 done"}, chk_done, 1);
    chk({tag, " R2/R11 err"}, err_code, e_err);
    chk({tag, " R7/R8 grant_rd"}, grant_rd, e_rd);
    chk({tag, " R7/R8 grant_wr"}, grant_wr, e_wr);
    chk({tag, " R9 trap_ifetch"}, trap_ifetch, e_ti);
    chk({tag, " R9 trap_data"}, trap_data, e_td);
    if (rd_status) chk({tag, " R10 read old status"}, reg_rdata, old_status);
  endtask

  task automatic read_reg(input bit sel, input string tag);
    int unsigned exp;
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    exp = sel ? m_addr : m_status;
    if (!sel) m_status = 0;
    @(negedge clk);
    reg_rd = 1'b0;
    chk({tag, " R12 rvalid"}, reg_rvalid, 1);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R12 done", chk_done, 0);
    chk("reset R12 err", err_code, 0);
    chk("reset R12 grants", {grant_rd, grant_wr, trap_ifetch, trap_data}, 0);
    read_reg(1'b0, "reset R12 status");
    read_reg(1'b1, "reset R12 addr");

    // R1 R2 R7 R9: full sweep of access index and permission
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 8; p++)
        run_chk(i[2], i[1], i[0], p, 1'b1, 0, 1'b0, 1'b0, 32'h1000_0000 + i * 16 + p, 1'b0, "sweep");
    read_reg(1'b0, "R3 status after sweep");
    read_reg(1'b0, "R10 status cleared by read");
    read_reg(1'b1, "R5 last fault addr");

    // R4 R1: user store to permission 0 on a clean log
    run_chk(1'b1, 1'b0, 1'b0, 0, 1'b1, 0, 1'b0, 1'b0, 32'hDEAD_BEEF, 1'b0, "R4 single");
    // R3: second fault before any read gives overflow
    run_chk(1'b0, 1'b1, 1'b0, 7, 1'b1, 0, 1'b0, 1'b0, 32'h0BAD_F00D, 1'b0, "R3 second");
    read_reg(1'b0, "R3 overflow status");
    read_reg(1'b1, "R5 addr after second");

    // R7: writable page, clean entry
    run_chk(1'b1, 1'b0, 1'b1, 5, 1'b0, 0, 1'b0, 1'b0, 32'h2000, 1'b0, "R7 clean");
    run_chk(1'b0, 1'b0, 1'b0, 5, 1'b1, 0, 1'b0, 1'b0, 32'h2004, 1'b0, "R7 user perm5");
    // R6: no-fault hides a permission error
    run_chk(1'b0, 1'b0, 1'b0, 6, 1'b1, 0, 1'b1, 1'b0, 32'h3000, 1'b0, "R6 nofault");
    read_reg(1'b0, "R6 status untouched");
    // R8: traps disabled
    run_chk(1'b1, 1'b0, 1'b0, 4, 1'b1, 0, 1'b0, 1'b1, 32'h4000, 1'b0, "R8 traps off");
    read_reg(1'b0, "R8 status logged");
    // R11: walker errors, trapping and with no-fault set
    run_chk(1'b0, 1'b1, 1'b1, 3, 1'b1, 'h104, 1'b0, 1'b0, 32'h5000, 1'b0, "R11 walk");
    run_chk(1'b1, 1'b0, 1'b1, 3, 1'b1, 'h310, 1'b1, 1'b0, 32'h6000, 1'b0, "R11 walk nf");
    read_reg(1'b0, "R11 walk status");
    read_reg(1'b1, "R11 walk addr");
    // R10: status read in the same cycle as a fault
    run_chk(1'b0, 1'b0, 1'b0, 4, 1'b1, 0, 1'b0, 1'b0, 32'h7000, 1'b0, "R10 prime");
    run_chk(1'b1, 1'b0, 1'b0, 0, 1'b1, 0, 1'b0, 1'b0, 32'h7004, 1'b1, "R10 same cycle");
    read_reg(1'b0, "R10 merged status");

    @(negedge clk);
    chk("idle R12 done low", chk_done, 0);
    chk("idle R9 traps low", {trap_ifetch, trap_data}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule